// File: doc/BRIEF.md
# Saturating Up-Down Level Filter

This block cleans up a slow, noisy level signal, such as a carrier-detect line, before other logic uses it. The raw level first passes through a synchronizer into the clock domain. It then drives an integrating counter that steps once on every sampling tick. The counter steps up while the level is high and down while it is low. It stops at either end of its range instead of wrapping. The top bit of the counter is the filtered output.

Brief glitches cancel out in the count. A new level must dominate for about half the counter's range before the output follows it. With a 10-bit counter and a tick near 492 Hz, that takes roughly one second. A separate divider provides the sampling tick, and the filtered level feeds whatever timer or control logic needs it.

Top module: `lvl_integ_filter`

## Requirements
- R1: While rst_n is low, and after it is released, the counter holds 0 and filt_lvl_o is 0. From that state, a steady high input raises the output only on the 512th applied tick.
- R2: The raw input passes through two flip-flops before it reaches the counter. A level change on raw_lvl_i is used by a tick only from the third rising clock edge after it is set up. The first two ticks still use the old level.
- R3: On a clock edge where tick_en_i is 0, the counter and filt_lvl_o keep their values.
- R4: On a tick with the synchronized level high and the count below 1023, the count goes up by one.
- R5: On a tick with the synchronized level low and the count above 0, the count goes down by one.
- R6: At 1023 with the level high, a tick leaves the count at 1023. It never wraps to 0.
- R7: At 0 with the level low, a tick leaves the count at 0. It never wraps to 1023.
- R8: filt_lvl_o is bit 9, the most significant bit, of the 10-bit count. It is 1 exactly when the count is 512 or more.
- R9: From full scale (1023), a low level keeps the output high for 511 ticks and drops it on the 512th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_en_i | input | 1 | Sampling-rate enable; the counter steps only when it is 1 |
| raw_lvl_i | input | 1 | Unsynchronized noisy level |
| filt_lvl_o | output | 1 | Filtered level, counter MSB |

## Verification
The output is a single bit, so a corrupted count shows only as a wrong number of ticks before the next output edge. The bench measures those tick counts exactly. A count that wraps at either end shows up about 512 ticks later, as a premature or missing output change when the level reverses. A tick that is not held off, or an extra or missing synchronizer stage, moves an output edge by one clock at the boundary count. That shift is caught on the very next sample.

// File: rtl/lvl_filt_pkg.sv
package lvl_filt_pkg;

  // Default integrator width: 2^(W-1) ticks to cross the output threshold
  parameter int unsigned LF_CNT_W_DEF  = 10;
  // Default synchronizer depth
  parameter int unsigned LF_SYNC_N_DEF = 2;

  // Step direction chosen by the synchronized level
  typedef enum logic {
    LF_DIR_DOWN = 1'b0,
    LF_DIR_UP   = 1'b1
  } lf_dir_e;

endpackage

// File: rtl/lvl_sync_chain.sv
module lvl_sync_chain #(
  parameter int unsigned STAGES = lvl_filt_pkg::LF_SYNC_N_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o == $past(stg_q[STAGES-2]));

  initial begin
    // R2
    sync_depth_chk: assert (STAGES >= 2);
  end

endmodule

// File: rtl/lvl_sat_counter.sv
module lvl_sat_counter
  import lvl_filt_pkg::*;
#(
  parameter int unsigned CNT_W = LF_CNT_W_DEF
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_en_i,
  input  lf_dir_e dir_i,
  output logic    msb_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = {CNT_W{1'b0}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_top;
  logic             at_bot;

  always_comb begin
    at_top = (cnt_q == CNT_MAX);
    at_bot = (cnt_q == CNT_MIN);
  end

  // Next-state: step once per tick, clamp at both rails
  always_comb begin
    cnt_d = cnt_q;
    if (tick_en_i) begin
      if (dir_i == LF_DIR_UP) begin
        if (!at_top) cnt_d = cnt_q + CNT_ONE;
      end else begin
        if (!at_bot) cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_MIN;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign msb_o = cnt_q[CNT_W-1];

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> $stable(cnt_q));

  // R4
  up_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en_i && dir_i == LF_DIR_UP) |=> cnt_q >= $past(cnt_q));

  // R5
  down_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en_i && dir_i == LF_DIR_DOWN) |=> cnt_q <= $past(cnt_q));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en_i && dir_i == LF_DIR_UP && at_top) |=> at_top);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en_i && dir_i == LF_DIR_DOWN && at_bot) |=> at_bot);

  // R4 R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_ONE) ||
    (cnt_q == $past(cnt_q) - CNT_ONE));

endmodule

// File: rtl/lvl_integ_filter.sv
module lvl_integ_filter
  import lvl_filt_pkg::*;
#(
  parameter int unsigned CNT_W   = LF_CNT_W_DEF,
  parameter int unsigned SYNC_N  = LF_SYNC_N_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  input  logic raw_lvl_i,
  output logic filt_lvl_o
);

  logic    lvl_sync;
  lf_dir_e step_dir;

  lvl_sync_chain #(
    .STAGES (SYNC_N)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_lvl_i),
    .q_o   (lvl_sync)
  );

  always_comb begin
    step_dir = lvl_sync ? LF_DIR_UP : LF_DIR_DOWN;
  end

  lvl_sat_counter #(
    .CNT_W (CNT_W)
  ) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en_i (tick_en_i),
    .dir_i     (step_dir),
    .msb_o     (filt_lvl_o)
  );

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> $stable(filt_lvl_o));

  // R8
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_lvl_o) |-> $past(lvl_sync));

  // R8
  out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_lvl_o) |-> !$past(lvl_sync));

endmodule

// File: tb/lvl_integ_filter_tb.sv
module lvl_integ_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;
  localparam int NVEC       = 13;

  // {level, tick count, expected output}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 10'd5,   1'b0},  // R7 floor hold, count 0
    {1'b1, 10'd511, 1'b0},  // R4 count 511
    {1'b1, 10'd1,   1'b1},  // R8 count 512
    {1'b0, 10'd1,   1'b0},  // R5 count 511
    {1'b1, 10'd1,   1'b1},  // R4 count 512
    {1'b1, 10'd600, 1'b1},  // R6 clamps at 1023
    {1'b0, 10'd511, 1'b1},  // R9 count 512
    {1'b0, 10'd1,   1'b0},  // R9 count 511
    {1'b0, 10'd600, 1'b0},  // R7 clamps at 0
    {1'b1, 10'd511, 1'b0},  // R7 no wrap: count 511
    {1'b1, 10'd1,   1'b1},  // R8 count 512
    {1'b0, 10'd1,   1'b0},  // R5 glitch down, 511
    {1'b1, 10'd1,   1'b1}   // R4 glitch up, 512
  };

  logic clk;
  logic rst_n;
  logic tick_en_i;
  logic raw_lvl_i;
  logic filt_lvl_o;

  int n_chk;
  int n_bad;

  lvl_integ_filter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en_i  (tick_en_i),
    .raw_lvl_i  (raw_lvl_i),
    .filt_lvl_o (filt_lvl_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (filt_lvl_o !== exp) begin
      n_bad++;
      $display("FAIL %s: filt_lvl_o=%b expected=%b", tag, filt_lvl_o, exp);
    end
  endtask

  // drive for n cycles, inputs change only at falling edges
  task automatic run(input int n, input logic en);
    for (int i = 0; i < n; i++) begin
      tick_en_i = en;
      @(negedge clk);
    end
    tick_en_i = 1'b0;
  endtask

  task automatic set_lvl(input logic lv);
    raw_lvl_i = lv;
    run(2, 1'b0);  // flush synchronizer without ticks
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run(3, 1'b0);
    rst_n = 1'b1;
    run(1, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYC);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    tick_en_i = 1'b0;
    raw_lvl_i = 1'b0;
    @(negedge clk);
    run(2, 1'b0);
    check(1'b0, "R1 output low in reset");
    rst_n = 1'b1;
    run(1, 1'b0);
    check(1'b0, "R1 output low after reset");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      set_lvl(VEC[v][11]);
      run(int'(VEC[v][10:1]), 1'b1);
      check(VEC[v][0], $sformatf("R4 R5 R6 R7 R8 R9 vector %0d", v));
    end

    // R3: count at 512, level low, no ticks for a long time
    set_lvl(1'b0);
    run(300, 1'b0);
    check(1'b1, "R3 output held without ticks");
    run(1, 1'b1);
    check(1'b0, "R3 count preserved at 512 during idle");

    // R1: reset in mid-run clears the count
    set_lvl(1'b1);
    run(5, 1'b1);
    check(1'b1, "R1 setup output high");
    rst_n = 1'b0;
    run(1, 1'b0);
    check(1'b0, "R1 output low under mid-run reset");
    rst_n = 1'b1;
    run(1, 1'b0);
    set_lvl(1'b1);
    run(511, 1'b1);
    check(1'b0, "R1 count restarted from zero (511 ticks)");
    run(1, 1'b1);
    check(1'b1, "R1 R8 output on 512th tick");

    // R2: count 511 with level high synced, then level drops with ticks on
    do_reset();
    set_lvl(1'b1);
    run(511, 1'b1);
    check(1'b0, "R2 setup count 511");
    raw_lvl_i = 1'b0;
    run(1, 1'b1);
    check(1'b1, "R2 first tick still uses old level");
    run(2, 1'b1);
    check(1'b1, "R2 count 512 after two old-level ticks and one new");
    run(1, 1'b1);
    check(1'b0, "R2 new level reaches counter on third edge");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule